// File: doc/BRIEF.md
# Ring-Addressed Serial Delay Line

This block delays a one-bit serial stream by a fixed number of clock cycles. From outside it behaves exactly like a long chain of one-bit flip-flops. Inside, the stages do not shift. The samples sit in a ring of enable registers, and on each clock only the slot picked by a wrapping pointer is written. This keeps storage toggling to at most one bit per cycle, where a shifting chain can toggle every bit.

The pointer drives two things. A one-hot decoder turns it into the write enables. A multiplexer tree uses the same pointer to read the slot about to be overwritten. That slot still holds the sample written one full lap earlier, so it is the sample that has aged by the delay length. The delay length `DEPTH` is a power of two. The pointer width is its base-2 logarithm, so the pointer wraps on natural overflow with no compare.

The read tree is built from radix-8 stages, each consuming three pointer bits starting at the least significant. A final 2-to-1 or 4-to-1 stage uses any pointer bits that are left over. With the default depth of 1024 the tree has three 8-to-1 levels (128, then 16, then 2 multiplexers) followed by one 2-to-1.

Top module: `ring_delay_line`

## Requirements
- R1: A synchronous reset sets the pointer to 0 and every storage slot to 0. For the first `DEPTH` cycles after reset is released, `dout_o` is 0.
- R2: Outside reset, the pointer rises by one on every clock and wraps from `DEPTH-1` to 0 with no extra cycle.
- R3: Every clock outside reset writes exactly one slot, the one addressed by the pointer, and that slot captures the current `din_i`.
- R4: Slots that are not addressed keep their value, so at most one storage bit changes per clock.
- R5: `dout_o` shows the contents of the addressed slot as they were before that cycle's write (read before write).
- R6: A sample applied to `din_i` before clock edge n appears on `dout_o` after clock edge n+`DEPTH`-1, that is, `DEPTH` cycles later. Cycle for cycle this matches a `DEPTH`-stage shift register fed the same stream.
- R7: The read tree selects slot p correctly for every pointer value p. Each radix-8 level is steered by its own three pointer bits (least significant first), and the final stage by the remaining top bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, delayed by `DEPTH` cycles |

## Verification
The embedded properties assume only that `rst_i` is synchronous and that `din_i` is stable at each rising edge. The bench meets this by changing both signals only at falling edges. The read-before-write and single-toggle properties also rely on nothing but the enable registers updating the storage. The stimulus runs one full lap per pointer bit, with `din_i` equal to that bit of the cycle number. This makes every tree level steer on a pattern that differs between its inputs, and a wrongly routed select bit shows up as a mismatch. A long random stretch and a reset in the middle of traffic follow, and the stretch after that reset must produce zeros.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

  // Number of nodes on tree level k (level 0 is the raw storage).
  function automatic int lvl_width(input int depth, input int k);
    return depth >> (3 * k);
  endfunction

  // Bit offset of tree level k inside the flat node vector.
  function automatic int lvl_off(input int depth, input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += lvl_width(depth, i);
    return acc;
  endfunction

  // Radix-8 levels that a pointer of width aw can steer.
  function automatic int radix8_levels(input int aw);
    return aw / 3;
  endfunction

endpackage

// File: rtl/rdl_ptr.sv
module rdl_ptr #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;
  logic          wrap_evt;

  always_ff @(posedge clk_i) begin
    if (rst_i) ptr_q <= '0;
    else       ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o    = ptr_q;
  assign wrap_evt = &ptr_q;

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap_evt |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R2
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_evt |=> (ptr_q == '0));
endmodule

// File: rtl/rdl_slot_dec.sv
module rdl_slot_dec #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [AW-1:0]    ptr_i,
  output logic [DEPTH-1:0] en_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_en
    assign en_o[i] = (ptr_i == AW'(i));
  end

  // R3
  en_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(en_o) == 1);
endmodule

// File: rtl/rdl_slots.sv
module rdl_slots #(
  parameter int DEPTH = 1024
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DEPTH-1:0] en_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] slot_o
);
  logic [DEPTH-1:0] slot_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (rst_i)        slot_q[i] <= 1'b0;
      else if (en_i[i]) slot_q[i] <= din_i;
    end
  end

  assign slot_o = slot_q;

  // R4
  single_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($countones(slot_q ^ $past(slot_q)) <= 1));
endmodule

// File: rtl/rdl_mux_tree.sv
module rdl_mux_tree
  import rdl_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic [DEPTH-1:0] data_i,
  input  logic [AW-1:0]    sel_i,
  output logic             bit_o
);
  localparam int L8     = radix8_levels(AW);
  localparam int RB     = AW - 3 * L8;
  localparam int FINOFF = lvl_off(DEPTH, L8);
  localparam int NF     = lvl_width(DEPTH, L8);
  localparam int TOT    = FINOFF + NF;

  logic [TOT-1:0] node;

  assign node[DEPTH-1:0] = data_i;

  for (genvar k = 0; k < L8; k++) begin : g_lvl
    localparam int IN_OFF  = lvl_off(DEPTH, k);
    localparam int OUT_OFF = lvl_off(DEPTH, k + 1);
    localparam int NOUT    = lvl_width(DEPTH, k + 1);
    for (genvar j = 0; j < NOUT; j++) begin : g_mux8
      logic [7:0] grp;
      assign grp                = node[IN_OFF + 8*j +: 8];
      assign node[OUT_OFF + j]  = grp[sel_i[3*k +: 3]];
    end
  end

  if (RB == 0) begin : g_fin_pass
    assign bit_o = node[FINOFF];
  end else begin : g_fin_mux
    logic [NF-1:0] fin;
    assign fin   = node[FINOFF +: NF];
    assign bit_o = fin[sel_i[AW-1 -: RB]];
  end
endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line #(
  parameter int DEPTH = 1024
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]    ptr;
  logic [DEPTH-1:0] wr_en;
  logic [DEPTH-1:0] slot;
  logic             rd_bit;

  rdl_ptr #(.AW(AW)) u_ptr (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ptr_o (ptr)
  );

  rdl_slot_dec #(.DEPTH(DEPTH), .AW(AW)) u_dec (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ptr_i (ptr),
    .en_o  (wr_en)
  );

  rdl_slots #(.DEPTH(DEPTH)) u_slots (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (wr_en),
    .din_i  (din_i),
    .slot_o (slot)
  );

  rdl_mux_tree #(.DEPTH(DEPTH), .AW(AW)) u_tree (
    .data_i (slot),
    .sel_i  (ptr),
    .bit_o  (rd_bit)
  );

  assign dout_o = rd_bit;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (ptr == '0 && slot == '0 && dout_o == 1'b0));

  // R3
  slot_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (slot[$past(ptr)] == $past(din_i)));

  // R5
  read_old_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ($past(dout_o) == $past(slot[ptr])));

  // R7
  tree_select_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    dout_o == slot[ptr]);
endmodule

// File: tb/test_ring_delay_line.sv
module test_ring_delay_line;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst;
  logic din;
  logic dout;

  int n_vec  = 0;
  int n_fail = 0;
  logic [DEPTH-1:0] model;

  always #2.5 clk = ~clk;

  ring_delay_line #(.DEPTH(DEPTH)) i_ring_delay_line (
    .clk_i  (clk),
    .rst_i  (rst),
    .din_i  (din),
    .dout_o (dout)
  );

  // Called at a falling edge: check output, drive next bit, advance one cycle.
  task automatic step(input logic d, input string req);
    logic exp;
    exp = model[DEPTH-1];
    n_vec++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%b expected %b", req, dout, exp);
    end
    din   = d;
    model = {model[DEPTH-2:0], d};
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    repeat (2) @(negedge clk);
    rst   = 1'b0;
    model = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : stim
    rst   = 1'b1;
    din   = 1'b0;
    model = '0;
    @(negedge clk);
    do_reset();

    // R1: zero output across the first lap after reset while ones go in
    for (int t = 0; t < DEPTH; t++) step(1'b1, "R1");

    // R2 R7: one lap per pointer bit, din = that bit of the cycle number
    for (int b = 0; b < AW; b++) begin
      for (int t = 0; t < DEPTH; t++) step(logic'((t >> b) & 1), "R7");
    end

    // R3 R4 R6: a single pulse in a field of zeros
    for (int t = 0; t < DEPTH; t++) step(logic'(t == 37), "R4");
    for (int t = 0; t < DEPTH; t++) step(1'b0, "R6");

    // R5 R6: random stream compared with a shift-register model
    for (int t = 0; t < 4000; t++) step(logic'($urandom & 1), "R6");

    // R1: reset in mid-traffic, then zeros again during the next lap
    do_reset();
    for (int t = 0; t < DEPTH; t++) step(logic'($urandom & 1), "R1");
    for (int t = 0; t < DEPTH; t++) step(1'b0, "R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule